// File: doc/BRIEF.md
# Serial Register Access Port

This block is the target side of a four-wire serial link. A host microcontroller reads and writes a small 8-bit register file through it using a 7-bit address. Every access is one 16-bit frame, enclosed by an active-low select. The host first sends a direction bit and the address, then 8 data bits. While the direction and address bits go out, the block returns a status byte on its serial output. That byte was captured when select fell, so the host can poll lock and FIFO state without spending a separate read. In the data phase the block either takes the write byte or returns the read byte.

The register file has a read-only identification register, a scratch register and eight general configuration registers, which drive a flat output bus. It also has a byte port into an external FIFO: a write frame to that address sends out a one-cycle push strobe with the byte, and a read frame sends out a one-cycle pop strobe and returns the head byte. The serial clock, select and data input are sampled by the faster system clock through synchronizers. Edges are found in the system clock domain.

Top module: `spi_regif`

## Requirements
- R1: A frame is 16 serial clock rising edges with MSB first: a direction bit (1 = write, 0 = read), then 7 address bits, then 8 data bits. The input line is sampled on rising edges, and a written byte reads back unchanged from a read/write register.
- R2: Address 0x00 reads 0x21 and ignores writes. Address 0x01 is a read/write scratch register that reads 0xC5 after reset.
- R3: Addresses 0x08..0x0F are read/write registers that reset to 0x00. Register 0x08+k appears on `cfg_o[8k+7:8k]`. `cfg_o` changes only while select is high.
- R4: The serial output changes only after falling serial clock edges or a select fall. Bit position 0 (the direction bit) returns 0. Positions 1..7 return, in order: PLL lock, FIFO overrun, FIFO underrun, FIFO full, FIFO empty, FIFO meta bit 1, FIFO meta bit 0.
- R5: The status bits are captured when select falls. Status inputs that change later in the frame do not alter the returned bits.
- R6: Positions 8..15 return the read byte MSB first on a read frame, and 0x00 on a write frame.
- R7: `spi_miso_oe` is low while select is high and high during a frame. It follows select with a delay of at most SYNC_STAGES+1 system clock cycles.
- R8: A write takes effect only if select rises after exactly 16 rising edges. Shorter and longer frames change nothing.
- R9: Addresses other than 0x00, 0x01, 0x05 and 0x08..0x0F read as 0x00. Writes to them change no register and give no FIFO strobe.
- R10: A complete write frame to 0x05 gives exactly one one-cycle `fifo_wr_o` pulse after select rises, with the byte on `fifo_wdata_o`.
- R11: A read frame to 0x05 gives exactly one one-cycle `fifo_rd_o` pulse once the address is complete and while select is low. The byte returned is `fifo_rdata_i` as it was just before that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sel_n | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| stat_pll_lock | input | 1 | Synthesizer lock flag |
| stat_fifo_over | input | 1 | FIFO overrun flag |
| stat_fifo_under | input | 1 | FIFO underrun flag |
| stat_fifo_full | input | 1 | FIFO full flag |
| stat_fifo_empty | input | 1 | FIFO empty flag |
| stat_fifo_meta | input | 2 | Meta bits of the FIFO head word |
| fifo_wr_o | output | 1 | FIFO push strobe |
| fifo_wdata_o | output | 8 | Byte to push |
| fifo_rd_o | output | 1 | FIFO pop strobe |
| fifo_rdata_i | input | 8 | FIFO head byte |
| cfg_o | output | 64 | General configuration registers, flattened |

## Verification
Directed frames target the fixed registers, the eight configuration registers, the FIFO port and unmapped addresses. This separates address decode faults from data-path faults. Frames of 12 and 17 bits check that only an exact 16-edge frame commits. A read in which the status inputs flip mid-frame shows whether the status is captured at select fall or sampled live. A long random mix of directions, addresses, data, status and FIFO head values is compared against a bench model. Every frame's whole returned 16-bit word, strobe counts and configuration bus are checked, which exposes bit-order, position and stale-data faults.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int STAT_W     = 7;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    localparam logic [ADDR_W-1:0] ADDR_ID      = 7'h00;
    localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 7'h01;
    localparam logic [ADDR_W-1:0] ADDR_FIFO    = 7'h05;
    // Base of the configuration block; must be aligned to GEN_COUNT.
    localparam logic [ADDR_W-1:0] ADDR_GEN     = 7'h08;
    localparam int GEN_COUNT = 8;
    localparam int GEN_IDX_W = $clog2(GEN_COUNT);

    localparam logic [DATA_W-1:0] ID_VALUE     = 8'h21;
    localparam logic [DATA_W-1:0] SCRATCH_INIT = 8'hC5;

    // Packed MSB first: the order in which the bits leave on the serial line.
    typedef struct packed {
        logic       pll_lock;
        logic       fifo_over;
        logic       fifo_under;
        logic       fifo_full;
        logic       fifo_empty;
        logic [1:0] fifo_meta;
    } status_t;

    typedef enum logic [2:0] {
        TGT_ID,
        TGT_SCRATCH,
        TGT_FIFO,
        TGT_GEN,
        TGT_NONE
    } target_e;

    typedef struct packed {
        target_e              kind;
        logic [GEN_IDX_W-1:0] idx;
    } target_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic target_t decode_addr(input logic [ADDR_W-1:0] a);
        target_t t;
        t.kind = TGT_NONE;
        t.idx  = a[GEN_IDX_W-1:0];
        if (a == ADDR_ID)
            t.kind = TGT_ID;
        else if (a == ADDR_SCRATCH)
            t.kind = TGT_SCRATCH;
        else if (a == ADDR_FIFO)
            t.kind = TGT_FIFO;
        else if (a[ADDR_W-1:GEN_IDX_W] == ADDR_GEN[ADDR_W-1:GEN_IDX_W])
            t.kind = TGT_GEN;
        return t;
    endfunction

    // Bit shown on the serial output at a given position of the frame.
    function automatic logic tx_bit(input logic [CNT_W-1:0] pos,
                                    input logic [STAT_W-1:0] stat,
                                    input logic [DATA_W-1:0] rdata);
        int p;
        p = int'(pos);
        if (p == 0)
            return 1'b0;
        else if (p <= STAT_W)
            return stat[STAT_W - p];
        else if (p < FRAME_BITS)
            return rdata[FRAME_BITS - 1 - p];
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst)
                chain <= {STAGES{RST_VAL[b]}};
            else
                chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_frame.sv
module spi_frame
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  status_t           stat_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              hdr_done_o,
    output logic              hdr_wr_o,
    output logic [ADDR_W-1:0] hdr_addr_o,
    output wr_req_t           wr_o,
    output logic              miso_o,
    output logic              oe_o,
    output logic              sclk_fall_o,
    output logic              sel_fall_o
);

    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] POS_END  = CNT_W'(FRAME_BITS);

    logic                  sclk_q, sel_q;
    logic                  active, sclk_rise, sel_rise;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      rx_cnt, tx_pos;
    logic [STAT_W-1:0]     stat_q;
    logic [DATA_W-1:0]     rdata_q;

    assign active      = ~sel_n_s;
    assign sclk_rise   = active & ~sclk_q & sclk_s;
    assign sclk_fall_o = active & sclk_q & ~sclk_s;
    assign sel_fall_o  = sel_q & ~sel_n_s;
    assign sel_rise    = ~sel_q & sel_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sel_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            sel_q  <= sel_n_s;
        end
    end

    // Receive path and frame counting
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            rx_cnt     <= '0;
            hdr_done_o <= 1'b0;
        end else begin
            hdr_done_o <= sclk_rise && (rx_cnt == CNT_HDR);
            if (sel_fall_o) begin
                rx_cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
                if (rx_cnt != CNT_SAT)
                    rx_cnt <= rx_cnt + 1'b1;
            end
        end
    end

    assign hdr_wr_o   = shreg[HDR_BITS-1];
    assign hdr_addr_o = shreg[ADDR_W-1:0];

    // Commit only frames of exactly FRAME_BITS edges
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_o <= '0;
        end else begin
            wr_o.valid <= sel_rise && (rx_cnt == CNT_FULL) && shreg[FRAME_BITS-1];
            if (sel_rise) begin
                wr_o.addr <= shreg[FRAME_BITS-2:DATA_W];
                wr_o.data <= shreg[DATA_W-1:0];
            end
        end
    end

    // Transmit path
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_pos  <= POS_END;
            stat_q  <= '0;
            rdata_q <= '0;
        end else if (sel_fall_o) begin
            tx_pos  <= '0;
            stat_q  <= stat_i;
            rdata_q <= '0;
        end else begin
            if (sclk_fall_o && tx_pos != POS_END)
                tx_pos <= tx_pos + 1'b1;
            if (hdr_done_o && !hdr_wr_o)
                rdata_q <= rdata_i;
        end
    end

    assign miso_o = tx_bit(tx_pos, stat_q, rdata_q);
    assign oe_o   = active;

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_regif_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  wr_req_t                     wr_i,
    input  logic [ADDR_W-1:0]           rd_addr_i,
    input  logic [DATA_W-1:0]           fifo_rdata_i,
    output logic [DATA_W-1:0]           rd_data_o,
    output logic [GEN_COUNT*DATA_W-1:0] cfg_o,
    output logic                        fifo_wr_o,
    output logic [DATA_W-1:0]           fifo_wdata_o
);

    target_t           wt, rt;
    logic [DATA_W-1:0] scratch_q;
    logic [DATA_W-1:0] gen_q [GEN_COUNT];

    assign wt = decode_addr(wr_i.addr);
    assign rt = decode_addr(rd_addr_i);

    always_ff @(posedge clk) begin
        if (rst)
            scratch_q <= SCRATCH_INIT;
        else if (wr_i.valid && wt.kind == TGT_SCRATCH)
            scratch_q <= wr_i.data;
    end

    for (genvar g = 0; g < GEN_COUNT; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                gen_q[g] <= '0;
            else if (wr_i.valid && wt.kind == TGT_GEN && wt.idx == GEN_IDX_W'(g))
                gen_q[g] <= wr_i.data;
        end
        assign cfg_o[g*DATA_W +: DATA_W] = gen_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr_o    <= 1'b0;
            fifo_wdata_o <= '0;
        end else begin
            fifo_wr_o <= wr_i.valid && wt.kind == TGT_FIFO;
            if (wr_i.valid && wt.kind == TGT_FIFO)
                fifo_wdata_o <= wr_i.data;
        end
    end

    always_comb begin
        case (rt.kind)
            TGT_ID:      rd_data_o = ID_VALUE;
            TGT_SCRATCH: rd_data_o = scratch_q;
            TGT_FIFO:    rd_data_o = fifo_rdata_i;
            TGT_GEN:     rd_data_o = gen_q[rt.idx];
            default:     rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        spi_sel_n,
    input  logic                        spi_sclk,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic                        spi_miso_oe,
    input  logic                        stat_pll_lock,
    input  logic                        stat_fifo_over,
    input  logic                        stat_fifo_under,
    input  logic                        stat_fifo_full,
    input  logic                        stat_fifo_empty,
    input  logic [1:0]                  stat_fifo_meta,
    output logic                        fifo_wr_o,
    output logic [DATA_W-1:0]           fifo_wdata_o,
    output logic                        fifo_rd_o,
    input  logic [DATA_W-1:0]           fifo_rdata_i,
    output logic [GEN_COUNT*DATA_W-1:0] cfg_o
);

    logic [2:0]        pins_s;
    status_t           stat;
    wr_req_t           wr_req;
    logic              hdr_done, hdr_wr;
    logic [ADDR_W-1:0] hdr_addr;
    logic [DATA_W-1:0] rd_data;
    logic              sclk_fall, sel_fall;
    target_t           hdr_tgt;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_sel_n, spi_sclk, spi_mosi}),
        .q  (pins_s)
    );

    assign stat = '{pll_lock:   stat_pll_lock,
                    fifo_over:  stat_fifo_over,
                    fifo_under: stat_fifo_under,
                    fifo_full:  stat_fifo_full,
                    fifo_empty: stat_fifo_empty,
                    fifo_meta:  stat_fifo_meta};

    spi_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .sel_n_s    (pins_s[2]),
        .sclk_s     (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .stat_i     (stat),
        .rdata_i    (rd_data),
        .hdr_done_o (hdr_done),
        .hdr_wr_o   (hdr_wr),
        .hdr_addr_o (hdr_addr),
        .wr_o       (wr_req),
        .miso_o     (spi_miso),
        .oe_o       (spi_miso_oe),
        .sclk_fall_o(sclk_fall),
        .sel_fall_o (sel_fall)
    );

    spi_regfile u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (wr_req),
        .rd_addr_i   (hdr_addr),
        .fifo_rdata_i(fifo_rdata_i),
        .rd_data_o   (rd_data),
        .cfg_o       (cfg_o),
        .fifo_wr_o   (fifo_wr_o),
        .fifo_wdata_o(fifo_wdata_o)
    );

    // Pop strobe one cycle after the read byte has been captured
    assign hdr_tgt = decode_addr(hdr_addr);

    always_ff @(posedge clk) begin
        if (rst)
            fifo_rd_o <= 1'b0;
        else
            fifo_rd_o <= hdr_done && !hdr_wr && hdr_tgt.kind == TGT_FIFO;
    end

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk (
    input logic        clk,
    input logic        rst,
    input logic        spi_miso,
    input logic        spi_miso_oe,
    input logic        fifo_wr_o,
    input logic        fifo_rd_o,
    input logic [63:0] cfg_o,
    input logic        sclk_fall,
    input logic        sel_fall
);

    // R4: output moves only after a serial falling edge or a select fall
    p_miso_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(spi_miso_oe) && spi_miso_oe && !$past(sclk_fall) && !$past(sel_fall))
        |-> $stable(spi_miso));

    p_push_single_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |=> !fifo_wr_o);

    p_push_not_pop_r10: assert property (@(posedge clk) disable iff (rst)
        !(fifo_wr_o && fifo_rd_o));

    p_pop_single_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |=> !fifo_rd_o);

    p_pop_in_frame_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |-> spi_miso_oe);

    p_push_after_frame_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |-> !spi_miso_oe);

    p_cfg_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_o) |-> !spi_miso_oe);

endmodule

bind spi_regif spi_regif_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .spi_miso   (spi_miso),
    .spi_miso_oe(spi_miso_oe),
    .fifo_wr_o  (fifo_wr_o),
    .fifo_rd_o  (fifo_rd_o),
    .cfg_o      (cfg_o),
    .sclk_fall  (sclk_fall),
    .sel_fall   (sel_fall)
);

// File: tb/tb_spi_regif.sv
`timescale 1ns/1ps
module tb_spi_regif;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sel_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic [6:0]  stat_drv = 7'h00;
    logic        fifo_wr_o, fifo_rd_o;
    logic [7:0]  fifo_wdata_o;
    logic [7:0]  fifo_rdata_i = 8'h00;
    logic [63:0] cfg_o;

    int checks = 0, failures = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [7:0] last_wd = 8'h00;
    logic [7:0] model [128];
    bit done = 0;

    always #2 clk = ~clk;

    spi_regif dut (
        .clk(clk), .rst(rst),
        .spi_sel_n(spi_sel_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .stat_pll_lock(stat_drv[6]), .stat_fifo_over(stat_drv[5]),
        .stat_fifo_under(stat_drv[4]), .stat_fifo_full(stat_drv[3]),
        .stat_fifo_empty(stat_drv[2]), .stat_fifo_meta(stat_drv[1:0]),
        .fifo_wr_o(fifo_wr_o), .fifo_wdata_o(fifo_wdata_o),
        .fifo_rd_o(fifo_rd_o), .fifo_rdata_i(fifo_rdata_i),
        .cfg_o(cfg_o)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (fifo_wr_o) begin
                wr_cnt <= wr_cnt + 1;
                last_wd <= fifo_wdata_o;
            end
            if (fifo_rd_o) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit mapped_rw(input logic [6:0] a);
        return (a == 7'h01) || (a[6:3] == 4'h1);
    endfunction

    function automatic logic [63:0] exp_cfg();
        logic [63:0] v;
        for (int g = 0; g < 8; g++) v[g*8 +: 8] = model[8 + g];
        return v;
    endfunction

    task automatic xfer(input logic [15:0] word, input int nbits, input int flip_at,
                        output logic [15:0] rx, output int oe_bad);
        rx = '0;
        oe_bad = 0;
        @(negedge clk);
        spi_sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? word[15 - i] : 1'b0;
            if (i == flip_at) stat_drv = ~stat_drv;
            repeat (HALF) @(negedge clk);
            if (i < 16) rx[15 - i] = spi_miso;
            if (!spi_miso_oe) oe_bad++;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_sel_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic txn(input bit wr, input logic [6:0] addr, input logic [7:0] data,
                       input int nbits, input int flip_at, input string req);
        logic [15:0] rx, exp_rx;
        logic [7:0]  rd_exp;
        logic [6:0]  st;
        int wr0, rd0, oe_bad;
        bit commit;
        wr0 = wr_cnt;
        rd0 = rd_cnt;
        st = stat_drv;
        rd_exp = (addr == 7'h05) ? fifo_rdata_i : model[addr];
        exp_rx = {1'b0, st, wr ? 8'h00 : rd_exp};
        commit = wr && (nbits == 16);
        xfer({wr, addr, data}, nbits, flip_at, rx, oe_bad);
        if (nbits >= 16)
            chk(rx == exp_rx, req, "returned frame", 64'(rx), 64'(exp_rx));
        chk(oe_bad == 0 && !spi_miso_oe, "R7", "output enable", 64'(oe_bad), 64'(0));
        chk(wr_cnt == wr0 + ((commit && addr == 7'h05) ? 1 : 0), "R10", "push count",
            64'(wr_cnt), 64'(wr0 + ((commit && addr == 7'h05) ? 1 : 0)));
        chk(rd_cnt == rd0 + ((!wr && addr == 7'h05 && nbits >= 8) ? 1 : 0), "R11", "pop count",
            64'(rd_cnt), 64'(rd0 + ((!wr && addr == 7'h05 && nbits >= 8) ? 1 : 0)));
        if (commit && addr == 7'h05)
            chk(last_wd == data, "R10", "push byte", 64'(last_wd), 64'(data));
        if (commit && mapped_rw(addr)) model[addr] = data;
        chk(cfg_o == exp_cfg(), "R3", "config bus", cfg_o, exp_cfg());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [6:0] a;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        model[0] = 8'h21;
        model[1] = 8'hC5;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // Reset state
        chk(!spi_miso_oe, "R7", "oe after reset", 64'(spi_miso_oe), 64'(0));
        chk(cfg_o == 64'h0, "R3", "config reset", cfg_o, 64'h0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R10", "no strobes at reset", 64'(wr_cnt + rd_cnt), 64'(0));

        // Fixed registers
        stat_drv = 7'b1010011;
        txn(0, 7'h00, 8'h00, 16, -1, "R2");
        stat_drv = 7'b0101100;
        txn(0, 7'h01, 8'h00, 16, -1, "R2");
        txn(1, 7'h00, 8'h55, 16, -1, "R2");
        txn(0, 7'h00, 8'h00, 16, -1, "R2");
        txn(1, 7'h01, 8'h3C, 16, -1, "R1");
        stat_drv = 7'b1111111;
        txn(0, 7'h01, 8'h00, 16, -1, "R1");

        // Configuration block
        for (int g = 0; g < 8; g++) txn(1, 7'(8 + g), 8'(8'h10 + g * 17), 16, -1, "R6");
        for (int g = 0; g < 8; g++) txn(0, 7'(8 + g), 8'h00, 16, -1, "R3");

        // Status capture at select fall
        stat_drv = 7'b1000110;
        txn(0, 7'h01, 8'h00, 16, 3, "R5");
        stat_drv = 7'b0011001;
        txn(0, 7'h09, 8'h00, 16, 10, "R4");

        // Frame length
        txn(1, 7'h01, 8'hAA, 12, -1, "R8");
        txn(1, 7'h01, 8'hAB, 17, -1, "R8");
        txn(1, 7'h0A, 8'hEE, 15, -1, "R8");
        txn(0, 7'h01, 8'h00, 16, -1, "R8");

        // Unmapped addresses
        txn(1, 7'h30, 8'h77, 16, -1, "R9");
        txn(0, 7'h30, 8'h00, 16, -1, "R9");
        txn(0, 7'h7F, 8'h00, 16, -1, "R9");
        txn(0, 7'h04, 8'h00, 16, -1, "R9");

        // FIFO port
        txn(1, 7'h05, 8'h9E, 16, -1, "R10");
        fifo_rdata_i = 8'h6B;
        txn(0, 7'h05, 8'h00, 16, -1, "R11");
        txn(1, 7'h05, 8'h12, 12, -1, "R10");

        // Random mix
        for (int n = 0; n < 70; n++) begin
            case ($urandom % 5)
                0: a = 7'h00;
                1: a = 7'h01;
                2: a = 7'h05;
                3: a = 7'(8 + ($urandom % 8));
                default: a = 7'($urandom);
            endcase
            stat_drv = 7'($urandom);
            fifo_rdata_i = 8'($urandom);
            txn(1'($urandom), a, 8'($urandom), 16, -1, "R1");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule